// File: doc/BRIEF.md
# I2C Bus Recovery Clock Sequencer

This block frees an I2C bus on which a target device has been left holding SDA low, typically after a transfer was cut short mid-byte. On a start pulse it drops the enable of the main I2C controller engine and takes over the SCL line through an open-drain drive. It then clocks the bus slowly until the stuck target lets go of SDA. When it finishes it hands the bus back to the controller and reports how the attempt ended.

The recovery clock runs at a fixed rate. Its half-period length in system clock cycles comes from two parameters: the system clock frequency and the recovery clock frequency. SCL is released and held high for one half period first. From then on, every high phase ends with a look at the bus:

- If SCL reads low, some device is clamping it and the sequence aborts.
- If SDA reads high, the target has let go and the sequence stops early.
- Otherwise another low pulse follows.

At most a fixed number of low pulses is issued. After the last one, SDA is examined one final time.

A one-cycle done pulse accompanies the result flags. The flags stay valid until the next start.

Top module: `i2c_unstick`

## Requirements
- R1: After reset SCL is released (`scl_pull_low`=0), `busy`=0, `ctrl_enable`=1, and `done`, `ok`, `err_scl_stuck` and `err_sda_low` are 0.
- R2: A start pulse accepted while idle sets `busy` and clears `ctrl_enable` from the next cycle. Both stay that way until the cycle in which `done` is 1, when `busy` returns to 0 and `ctrl_enable` to 1.
- R3: The first half period after start holds SCL released. Every half period lasts HALF_CYC system cycles, so `busy` stays high for exactly HALF_CYC*(2*P+1) cycles, where P is the number of low pulses issued.
- R4: At the end of each high phase, SDA read high ends the sequence with no further pulses. If SDA is already high at the first check, zero pulses are issued.
- R5: No more than MAX_PULSES (default 9) low pulses are issued per run.
- R6: If SCL reads low at the end of a high phase, the run ends with `err_scl_stuck`=1 and no further pulses.
- R7: If SDA still reads low when the run ends, `err_sda_low`=1. On the end after the last allowed pulse, SDA is the only line checked.
- R8: `done` is a single-cycle pulse. `ok` is 1 exactly when both error flags are 0. The result flags hold their values while idle and are cleared by the next accepted start.
- R9: SCL is released (`scl_pull_low`=0) in the cycle `done` is 1, on every exit path.
- R10: A start pulse while `busy` is 1 has no effect on the pulse count, duration or result of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin recovery |
| scl_in | input | 1 | SCL line level as seen on the bus (asynchronous) |
| sda_in | input | 1 | SDA line level as seen on the bus (asynchronous) |
| scl_pull_low | output | 1 | Open-drain drive: 1 pulls SCL low, 0 releases it |
| ctrl_enable | output | 1 | Enable for the main controller engine, 0 during recovery |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| ok | output | 1 | Run ended with SDA high and SCL healthy |
| err_scl_stuck | output | 1 | SCL read low at a high-phase check |
| err_sda_low | output | 1 | SDA still low at the end of the run |

## Verification
The bench models a target that lets go of SDA after a chosen number of SCL falling edges, and a bus that can clamp SCL low after a chosen number of pulses. The cases are:

- SDA already free at the first check: a design that skipped it would emit a needless pulse and take 20 cycles too long.
- Release on exactly the ninth pulse: an off-by-one pulse limit would either report a false SDA error or clock a tenth pulse.
- A target that never releases: this exposes a limit that is ignored and shows whether the final SDA error is raised.
- SCL clamped from the start, and SCL clamped after three pulses: a design without the stuck check would keep toggling and report success or an SDA error instead.
- A second start pulse in the middle of a run: this catches a sequencer that restarts, because it would stretch the run.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } unstick_state_t;

  function automatic int half_cycles(input int clk_hz, input int scl_hz);
    return clk_hz / (2 * scl_hz);
  endfunction
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int HALF_CYC = 500,
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  logic [CW-1:0] cnt;

  assign tick = !hold && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || hold || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import unstick_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic scl_s,
  input  logic sda_s,
  output logic timer_hold,
  output logic drv_low,
  output logic ctrl_en,
  output logic busy_o,
  output logic done_o,
  output logic ok_o,
  output logic err_scl_o,
  output logic err_sda_o
);
  unstick_state_t state;
  logic [PW-1:0]  pulses;
  logic           high_end, last_pulse, stuck, finish;

  always_comb begin
    high_end   = (state == ST_HIGH) && tick;
    last_pulse = (pulses == PW'(MAX_PULSES));
    stuck      = !last_pulse && !scl_s;
    finish     = high_end && (last_pulse || stuck || sda_s);
  end

  assign timer_hold = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pulses    <= '0;
      drv_low   <= 1'b0;
      ctrl_en   <= 1'b1;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
      err_scl_o <= 1'b0;
      err_sda_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_HIGH;
            pulses    <= '0;
            drv_low   <= 1'b0;
            ctrl_en   <= 1'b0;
            busy_o    <= 1'b1;
            ok_o      <= 1'b0;
            err_scl_o <= 1'b0;
            err_sda_o <= 1'b0;
          end
        end
        ST_HIGH: begin
          if (finish) begin
            state     <= ST_IDLE;
            drv_low   <= 1'b0;
            ctrl_en   <= 1'b1;
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            ok_o      <= !stuck && sda_s;
            err_scl_o <= stuck;
            err_sda_o <= !sda_s;
          end else if (high_end) begin
            state   <= ST_LOW;
            drv_low <= 1'b1;
            pulses  <= pulses + 1'b1;
          end
        end
        ST_LOW: begin
          if (tick) begin
            state   <= ST_HIGH;
            drv_low <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import unstick_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_CYC   = half_cycles(CLK_HZ, SCL_HZ)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull_low,
  output logic ctrl_enable,
  output logic busy,
  output logic done,
  output logic ok,
  output logic err_scl_stuck,
  output logic err_sda_low
);
  logic [1:0] raw, synced;
  logic       tick, hold;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    unstick_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(synced[g])
    );
  end

  unstick_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick)
  );

  unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .scl_s(synced[0]), .sda_s(synced[1]),
    .timer_hold(hold), .drv_low(scl_pull_low), .ctrl_en(ctrl_enable),
    .busy_o(busy), .done_o(done), .ok_o(ok),
    .err_scl_o(err_scl_stuck), .err_sda_o(err_sda_low)
  );
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scl_pull_low,
  input logic ctrl_enable,
  input logic busy,
  input logic done,
  input logic ok,
  input logic err_scl_stuck,
  input logic err_sda_low
);
  int  seen;
  logic drv_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 0;
      drv_d <= 1'b0;
    end else begin
      drv_d <= scl_pull_low;
      if (!busy && start)              seen <= 0;
      else if (scl_pull_low && !drv_d) seen <= seen + 1;
    end
  end

  a_r2_enable_off_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctrl_enable);
  a_r5_pulse_limit: assert property (@(posedge clk) disable iff (rst)
    seen <= MAX_PULSES);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_ok_consistent: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok == !(err_scl_stuck || err_sda_low)));
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable({ok, err_scl_stuck, err_sda_low}));
  a_r9_release_on_exit: assert property (@(posedge clk) disable iff (rst)
    done |-> !scl_pull_low);
endmodule

bind i2c_unstick i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .scl_pull_low(scl_pull_low),
  .ctrl_enable(ctrl_enable), .busy(busy), .done(done), .ok(ok),
  .err_scl_stuck(err_scl_stuck), .err_sda_low(err_sda_low)
);

// File: tb/sim_i2c_unstick.sv
module sim_i2c_unstick;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;

  typedef struct {
    int pulses;
    bit ok;
    bit escl;
    bit esda;
  } exp_t;

  logic clk = 0, rst = 1, start = 0;
  logic scl_pull_low, ctrl_enable, busy, done, ok, err_scl_stuck, err_sda_low;
  logic scl_line, sda_line, clr_falls = 0, prev_scl = 1;
  int   falls = 0, sda_rel = 0, stuck_after = -1;
  int   checks = 0, errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !scl_pull_low && !(stuck_after >= 0 && falls >= stuck_after);
  assign sda_line = (falls >= sda_rel);

  always @(posedge clk) begin
    prev_scl <= scl_line;
    if (clr_falls)                 falls <= 0;
    else if (prev_scl && !scl_line) falls <= falls + 1;
  end

  i2c_unstick #(.CLK_HZ(2_000_000), .SCL_HZ(100_000), .MAX_PULSES(9)) u0 (
    .clk(clk), .rst(rst), .start(start), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_pull_low), .ctrl_enable(ctrl_enable), .busy(busy),
    .done(done), .ok(ok), .err_scl_stuck(err_scl_stuck), .err_sda_low(err_sda_low)
  );

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  int  m_busy = 0, m_pulses = 0;
  bit  m_drv_d = 0, m_en_bad = 0, m_done_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) m_busy++;
      if (busy && ctrl_enable) m_en_bad = 1;
      if (scl_pull_low && !m_drv_d) m_pulses++;
      m_drv_d = scl_pull_low;
      if (done) begin
        exp_t e;
        if (sb.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          e = sb.pop_front();
          chk(m_pulses == e.pulses, "R4/R5 pulse count", m_pulses, e.pulses);
          chk(m_busy == HALF*(2*e.pulses+1), "R3 run length", m_busy, HALF*(2*e.pulses+1));
          chk(err_scl_stuck == e.escl, "R6 scl stuck flag", err_scl_stuck, e.escl);
          chk(err_sda_low == e.esda, "R7 sda low flag", err_sda_low, e.esda);
          chk(ok == e.ok, "R8 ok flag", ok, e.ok);
          chk(!scl_pull_low, "R9 scl released at done", scl_pull_low, 0);
          chk(!busy && ctrl_enable && !m_en_bad, "R2 enable handback", ctrl_enable, 1);
        end
        m_busy = 0; m_pulses = 0; m_en_bad = 0;
      end
      if (m_done_prev) chk(!done, "R8 done single cycle", done, 0);
      m_done_prev = done;
    end
  end

  task automatic run(input int rel, input int stk, input int p, input bit oke,
                     input bit se, input bit de, input bit poke_mid);
    exp_t e;
    @(negedge clk);
    clr_falls = 1; sda_rel = rel; stuck_after = stk;
    @(negedge clk);
    clr_falls = 0;
    repeat (4) @(negedge clk);
    e.pulses = p; e.ok = oke; e.escl = se; e.esda = de;
    sb.push_back(e);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !ctrl_enable, "R2 busy after start", busy, 1);
    if (poke_mid) begin
      repeat (25) @(negedge clk);
      start = 1;                 // R10: must be ignored
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(err_scl_stuck == se && err_sda_low == de && ok == oke,
        "R8 flags hold while idle", {ok, err_scl_stuck, err_sda_low}, {oke, se, de});
    chk(!scl_pull_low && ctrl_enable, "R9 scl stays released", scl_pull_low, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!scl_pull_low && !busy && ctrl_enable && !done && !ok && !err_scl_stuck && !err_sda_low,
        "R1 reset state", {scl_pull_low, busy, ctrl_enable, done}, 4'b0010);
    run(0, -1, 0, 1, 0, 0, 0);   // R4 already free
    run(1, -1, 1, 1, 0, 0, 0);   // R4 one pulse
    run(4, -1, 4, 1, 0, 0, 1);   // R10 start mid-run ignored
    run(9, -1, 9, 1, 0, 0, 0);   // R5 release on last pulse
    run(10, -1, 9, 0, 0, 1, 0);  // R5 R7 never releases
    run(20, 0, 0, 0, 1, 1, 0);   // R6 clamped from start, SDA low
    run(0, 0, 0, 0, 1, 0, 0);    // R6 clamped, SDA high
    run(20, 3, 3, 0, 1, 1, 0);   // R6 clamped after three pulses
    chk(sb.size() == 0, "R8 every run reported done", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule